// File: doc/BRIEF.md
# Prescaled Saturating Charge Accumulator

This block turns a stream of signed charge quanta into a 16-bit accumulated charge value. An analog integrator's polarity logic delivers one-cycle up and down pulses. The block divides them by a programmable power-of-two factor M = 2^scale_sel_i, which runs from 1 to 128. Each time the divided count completes a full step, the accumulated value moves by one. The value clamps at its end points and does not wrap. Reaching or pressing against an end point produces a one-cycle event.

The block has three other controls. A charge-complete input, when enabled, forces the value to full scale and holds it there for as long as the input stays high. A shutdown input stops all counting and discards any partial count held in the divider. A host write port replaces the value outright. The block comes out of reset at mid-scale, because the state of the battery is unknown at that point.

Top module: `chg_accum`

## Requirements
- R1: After reset, acr_o is 16'h7FFF and limit_evt_o is 0. The internal scale memory resets to select 3'b111, so applying select 7 in the first cycle after reset counts as no change.
- R2: With M = 2^scale_sel_i, the M-th net up pulse raises acr_o by one and the M-th net down pulse lowers it by one. The partial count (the residue) stays strictly between -M and +M. Every change in acr_o appears one clock after the pulse that completes the step.
- R3: When up_i and dn_i are high in the same cycle, the pair has no effect on the residue or on acr_o.
- R4: acr_o never wraps. An up step at 16'hFFFF leaves it at 16'hFFFF, and a down step at 16'h0000 leaves it at 16'h0000.
- R5: limit_evt_o is high for exactly one cycle after a count step that starts at 16'hFFFE or 16'hFFFF going up, or at 16'h0001 or 16'h0000 going down. Writes and presets never raise it.
- R6: While cc_en_i and cc_in_i are both 1, acr_o becomes 16'hFFFF one cycle later and stays there. Pulses and host writes are ignored and the residue is cleared. cc_in_i has no effect when cc_en_i is 0.
- R7: While shdn_i is 1, no pulse is counted and the residue is cleared to 0.
- R8: When wr_en_i is 1 (and no preset is active), acr_o equals wr_data_i one cycle later. Any step completed in that same cycle is lost.
- R9: A change of scale_sel_i clears the residue to 0. A pulse arriving in the cycle of the change is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_i | input | 1 | One charge quantum in the positive direction |
| dn_i | input | 1 | One charge quantum in the negative direction |
| scale_sel_i | input | 3 | Divider exponent, M = 2^scale_sel_i |
| cc_en_i | input | 1 | Enables the charge-complete preset |
| cc_in_i | input | 1 | Charge-complete level from the charger |
| shdn_i | input | 1 | Shutdown: stop counting and drop the residue |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | 16 | Host write value |
| acr_o | output | 16 | Accumulated charge value |
| limit_evt_o | output | 1 | One-cycle overflow/underflow event |

## Verification
Several functions can fall in the same clock cycle:
- A host write or a charge-complete preset can meet a step that the divider completes.
- Shutdown or a change of scale can meet a pulse that would have finished a step.

The bench provokes these collisions on purpose: it sets the residue to M-1 and then, in the next cycle, issues both the finishing pulse and the competing control. It judges the outcome against a behavioural reference model on every clock, checking that the priority held (preset over write over step) and that the partial count was discarded rather than carried. A long random phase then mixes all the inputs so that such collisions also occur without being planned.

// File: rtl/chg_pkg.sv
package chg_pkg;
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;
endpackage

// File: rtl/chg_prescale.sv
module chg_prescale
    import chg_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_i,
    input  logic             dn_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             clear_i,
    output step_e            step_o
);
    localparam int MAX_SH = (1 << SEL_W) - 1;
    localparam int RES_W  = MAX_SH + 2;

    typedef struct packed {
        logic [SEL_W-1:0]        sel;
        logic signed [RES_W-1:0] res;
    } pre_t;

    pre_t pre_q, pre_d;
    step_e step_d;

    logic signed [RES_W-1:0] m_val;
    logic signed [RES_W-1:0] m_q;
    logic signed [RES_W-1:0] net;
    logic signed [RES_W-1:0] sum;

    always_comb begin
        m_val  = $signed({{(RES_W-1){1'b0}}, 1'b1} << sel_i);
        m_q    = $signed({{(RES_W-1){1'b0}}, 1'b1} << pre_q.sel);
        net    = '0;
        if (up_i && !dn_i) net = $signed({{(RES_W-1){1'b0}}, 1'b1});
        if (dn_i && !up_i) net = '1;
        sum    = pre_q.res + net;
        pre_d  = pre_q;
        step_d = STEP_NONE;
        pre_d.sel = sel_i;
        if (clear_i || (sel_i != pre_q.sel)) begin
            pre_d.res = '0;
        end else if (sum == m_val) begin
            pre_d.res = '0;
            step_d    = STEP_UP;
        end else if (sum == -m_val) begin
            pre_d.res = '0;
            step_d    = STEP_DOWN;
        end else begin
            pre_d.res = sum;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q.sel <= '1;
            pre_q.res <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    assign step_o = step_d;

    // R2
    residue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_q.res < m_q) && (pre_q.res > -m_q));

    // R7
    shdn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (pre_q.res == '0));

    // R3
    cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_i && dn_i && !clear_i && (sel_i == pre_q.sel)) |=> $stable(pre_q.res));

    // R9
    scale_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i != pre_q.sel) |-> (step_o == STEP_NONE));
endmodule

// File: rtl/chg_sat_reg.sv
module chg_sat_reg
    import chg_pkg::*;
#(
    parameter int ACR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_e            step_i,
    input  logic             preset_i,
    input  logic             wr_en_i,
    input  logic [ACR_W-1:0] wr_data_i,
    output logic [ACR_W-1:0] acr_o,
    output logic             evt_o
);
    localparam logic [ACR_W-1:0] TOP = '1;
    localparam logic [ACR_W-1:0] BOT = '0;
    localparam logic [ACR_W-1:0] MID = {1'b0, {(ACR_W-1){1'b1}}};
    localparam logic [ACR_W-1:0] ONE = {{(ACR_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [ACR_W-1:0] acr;
        logic             evt;
    } acc_t;

    acc_t acc_q, acc_d;

    always_comb begin
        acc_d     = acc_q;
        acc_d.evt = 1'b0;
        if (preset_i) begin
            acc_d.acr = TOP;
        end else if (wr_en_i) begin
            acc_d.acr = wr_data_i;
        end else if (step_i == STEP_UP) begin
            if (acc_q.acr != TOP) acc_d.acr = acc_q.acr + ONE;
            acc_d.evt = (acc_q.acr >= TOP - ONE);
        end else if (step_i == STEP_DOWN) begin
            if (acc_q.acr != BOT) acc_d.acr = acc_q.acr - ONE;
            acc_d.evt = (acc_q.acr <= ONE);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q.acr <= MID;
            acc_q.evt <= 1'b0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign acr_o = acc_q.acr;
    assign evt_o = acc_q.evt;

    // R4
    no_wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q.acr == TOP && !preset_i && !wr_en_i) |=> (acc_q.acr != BOT));

    // R4
    no_wrap_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q.acr == BOT && !preset_i && !wr_en_i) |=> (acc_q.acr != TOP));

    // R6
    preset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preset_i |=> (acc_q.acr == TOP && !acc_q.evt));

    // R8
    host_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !preset_i) |=> (acc_q.acr == $past(wr_data_i)));

    // R2
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !preset_i) |=>
            ((acc_q.acr == $past(acc_q.acr)) ||
             (acc_q.acr == $past(acc_q.acr) + ONE) ||
             (acc_q.acr == $past(acc_q.acr) - ONE)));

    // R5
    evt_only_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == STEP_NONE || preset_i || wr_en_i) |=> !acc_q.evt);
endmodule

// File: rtl/chg_accum.sv
module chg_accum
    import chg_pkg::*;
#(
    parameter int ACR_W = 16,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_i,
    input  logic             dn_i,
    input  logic [SEL_W-1:0] scale_sel_i,
    input  logic             cc_en_i,
    input  logic             cc_in_i,
    input  logic             shdn_i,
    input  logic             wr_en_i,
    input  logic [ACR_W-1:0] wr_data_i,
    output logic [ACR_W-1:0] acr_o,
    output logic             limit_evt_o
);
    logic  cc_hold;
    logic  pre_clear;
    step_e step;

    assign cc_hold   = cc_en_i && cc_in_i;
    assign pre_clear = shdn_i || cc_hold;

    chg_prescale #(.SEL_W(SEL_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .up_i    (up_i),
        .dn_i    (dn_i),
        .sel_i   (scale_sel_i),
        .clear_i (pre_clear),
        .step_o  (step)
    );

    chg_sat_reg #(.ACR_W(ACR_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step),
        .preset_i  (cc_hold),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .acr_o     (acr_o),
        .evt_o     (limit_evt_o)
    );

    // R7
    shdn_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shdn_i && !cc_hold && !wr_en_i) |=> $stable(acr_o));
endmodule

// File: tb/test_chg_accum.sv
`timescale 1ns/1ps
module test_chg_accum;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_i = 0, dn_i = 0, cc_en_i = 0, cc_in_i = 0, shdn_i = 0, wr_en_i = 0;
    logic [2:0]  scale_sel_i = 3'd7;
    logic [15:0] wr_data_i = '0;
    logic [15:0] acr_o;
    logic        limit_evt_o;

    int total = 0, bad = 0;
    bit done = 0;
    string phase = "R1";

    int exp_acr, exp_res, exp_sel;
    bit exp_evt;

    always #2 clk = ~clk;

    chg_accum i_chg_accum (
        .clk(clk), .rst_n(rst_n), .up_i(up_i), .dn_i(dn_i),
        .scale_sel_i(scale_sel_i), .cc_en_i(cc_en_i), .cc_in_i(cc_in_i),
        .shdn_i(shdn_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .acr_o(acr_o), .limit_evt_o(limit_evt_o)
    );

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_acr = 32'h7FFF; exp_res = 0; exp_sel = 7; exp_evt = 0;
        end else begin
            int m, st;
            m = 1 << scale_sel_i;
            st = 0;
            exp_evt = 0;
            if ((cc_en_i && cc_in_i) || shdn_i || (int'(scale_sel_i) != exp_sel)) begin
                exp_res = 0;
            end else begin
                exp_res = exp_res + (up_i ? 1 : 0) - (dn_i ? 1 : 0);
                if (exp_res == m)  begin st = 1;  exp_res = 0; end
                if (exp_res == -m) begin st = -1; exp_res = 0; end
            end
            exp_sel = scale_sel_i;
            if (cc_en_i && cc_in_i) exp_acr = 32'hFFFF;
            else if (wr_en_i) exp_acr = wr_data_i;
            else if (st == 1) begin
                exp_evt = (exp_acr >= 32'hFFFE);
                if (exp_acr < 32'hFFFF) exp_acr++;
            end else if (st == -1) begin
                exp_evt = (exp_acr <= 1);
                if (exp_acr > 0) exp_acr--;
            end
        end
    end

    // per-clock comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            total++;
            if (int'(acr_o) != exp_acr || limit_evt_o != exp_evt) begin
                bad++;
                $display("FAIL %s model: acr=%h evt=%0d expected acr=%h evt=%0d",
                         phase, acr_o, limit_evt_o, exp_acr[15:0], exp_evt);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic cyc(input bit u, input bit d);
        up_i = u; dn_i = d;
        @(negedge clk);
        up_i = 0; dn_i = 0;
    endtask

    task automatic pulses(input int n, input bit u);
        for (int i = 0; i < n; i++) cyc(u, !u);
    endtask

    task automatic hwrite(input logic [15:0] v);
        wr_en_i = 1; wr_data_i = v;
        @(negedge clk);
        wr_en_i = 0;
    endtask

    task automatic set_sel(input logic [2:0] s);
        scale_sel_i = s;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset value", acr_o, 16'h7FFF);
        chk("R1 reset event", limit_evt_o, 0);

        phase = "R2";
        set_sel(3'd0);
        pulses(5, 1);
        chk("R2 M=1 up", acr_o, 16'h8004);
        set_sel(3'd2);
        pulses(7, 1);
        chk("R2 M=4 seven ups", acr_o, 16'h8005);
        pulses(3, 0);
        chk("R2 M=4 residue back to 0", acr_o, 16'h8005);
        pulses(4, 0);
        chk("R2 M=4 four downs", acr_o, 16'h8004);

        phase = "R3";
        set_sel(3'd0);
        for (int i = 0; i < 3; i++) cyc(1, 1);
        chk("R3 cancel", acr_o, 16'h8004);

        phase = "R4";
        hwrite(16'hFFFD);
        chk("R8 write", acr_o, 16'hFFFD);
        cyc(1, 0);
        chk("R5 no event mid", limit_evt_o, 0);
        cyc(1, 0);
        chk("R5 event reach top", limit_evt_o, 1);
        cyc(1, 0);
        chk("R4 saturate top", acr_o, 16'hFFFF);
        chk("R5 event press top", limit_evt_o, 1);
        cyc(0, 0);
        chk("R5 event one cycle", limit_evt_o, 0);
        hwrite(16'h0002);
        pulses(3, 0);
        chk("R4 saturate bottom", acr_o, 16'h0000);
        chk("R5 event bottom", limit_evt_o, 1);

        phase = "R6";
        cc_en_i = 1; cc_in_i = 1;
        cyc(0, 1);
        wr_en_i = 1; wr_data_i = 16'h1234;
        cyc(0, 1);
        wr_en_i = 0;
        chk("R6 preset hold over write", acr_o, 16'hFFFF);
        cc_in_i = 0;
        cyc(0, 1);
        chk("R6 counting resumes", acr_o, 16'hFFFE);
        cc_en_i = 0;
        hwrite(16'h1000);
        cc_in_i = 1;
        @(negedge clk);
        cc_in_i = 0;
        chk("R6 no effect when disabled", acr_o, 16'h1000);

        phase = "R7";
        set_sel(3'd2);
        hwrite(16'h2000);
        pulses(3, 1);
        shdn_i = 1;
        cyc(1, 0);
        cyc(1, 0);
        shdn_i = 0;
        chk("R7 no count in shutdown", acr_o, 16'h2000);
        pulses(1, 1);
        chk("R7 residue dropped", acr_o, 16'h2000);
        pulses(3, 1);
        chk("R7 fresh count", acr_o, 16'h2001);

        phase = "R9";
        pulses(3, 1);
        scale_sel_i = 3'd1;
        cyc(1, 0);
        pulses(1, 1);
        chk("R9 residue cleared", acr_o, 16'h2001);
        pulses(1, 1);
        chk("R9 new scale", acr_o, 16'h2002);

        phase = "R8";
        set_sel(3'd0);
        wr_en_i = 1; wr_data_i = 16'h4444;
        cyc(1, 0);
        wr_en_i = 0;
        chk("R8 step lost under write", acr_o, 16'h4444);

        phase = "R2/R5/R6/R7/R8/R9 random";
        for (int i = 0; i < 20000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            up_i = $urandom_range(0, 1);
            dn_i = $urandom_range(0, 1);
            if (r < 3) scale_sel_i = 3'($urandom_range(0, 3));
            shdn_i  = (r >= 3 && r < 6);
            cc_en_i = (r >= 6 && r < 9);
            cc_in_i = (r >= 6 && r < 8) || (r == 50);
            wr_en_i = (r == 9);
            wr_data_i = (r & 1) ? 16'hFFFE : 16'h0001;
            @(negedge clk);
        end
        {up_i, dn_i, shdn_i, cc_en_i, cc_in_i, wr_en_i} = '0;
        @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule